// File: doc/BRIEF.md
# Two-Bank SDRAM Command Sequencer

This block turns single-word read and write requests from a host into the command stream of a two-bank SDR SDRAM. The host presents a flat word address, a read/write flag and a valid strobe. The block accepts the request when its ready output is high. It then splits the address into a bank, an 11-bit row and an 8-bit column. It drives an ACTIVE command, and after the row-to-column delay it drives a READ or WRITE with auto-precharge requested. After that it holds off further commands until the burst, the CAS latency and the precharge time have all elapsed. It also reports the cycles in which read data would return and the cycles in which write data is taken.

After reset the block waits a configurable power-up time. It then precharges all banks, issues two AUTO REFRESH commands and programs the mode register with the burst length and CAS latency. Only after that does it begin accepting requests. From then on an internal timer, sized from the clock frequency and a selectable refresh budget, raises a refresh request. A waiting refresh wins over a host request once the current access and its precharge have finished.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is held, chip select is high, RAS#/CAS#/WE# are high, the bank and address outputs are zero, and reqReady, rdValid and wrTake are low.
- R2: Cycle n is the cycle after the n-th rising edge following reset release. A PRECHARGE with A10 high appears in cycle POWERUP_CYC. AUTO REFRESH appears in cycle POWERUP_CYC+T_RP and again T_RC cycles later. LOAD MODE REGISTER follows T_RC cycles after that. Every other cycle after reset shows NOP with chip select low, and NOP drives bank and address as zero.
- R3: LOAD MODE REGISTER drives bank 0 and an address with CAS latency in bits 6:4 and the burst length code in bits 2:0 (1→0, 2→1, 4→2, 8→3). All other bits are zero, which selects sequential bursts and burst writes.
- R4: reqReady is high only when no access is in progress, no refresh is waiting and the last command's gap has elapsed. It first rises in the cycle before cycle MRS+T_MRD, and it falls in the cycle after an acceptance.
- R5: A request is accepted on a rising edge where reqValid and reqReady are both high. ACTIVE then appears in the next cycle, with BA equal to reqAddr[19] and A10:A0 equal to reqAddr[18:8].
- R6: T_RCD cycles after ACTIVE, a READ (reqWrite low) or a WRITE (reqWrite high) appears. It carries the same bank, with A7:A0 equal to reqAddr[7:0], A10 high (auto-precharge) and A9:A8 zero.
- R7: After a READ the next command comes no sooner than max(CAS_LAT+BURST_LEN+T_RP, T_RC−T_RCD) cycles. After a WRITE the gap is max(BURST_LEN+T_WR+T_RP, T_RC−T_RCD) cycles. reqReady returns in the cycle before that point.
- R8: rdValid is high exactly in cycles r+CAS_LAT through r+CAS_LAT+BURST_LEN−1, where r is the cycle of a READ.
- R9: wrTake is high exactly in cycles w through w+BURST_LEN−1, where w is the cycle of a WRITE.
- R10: The refresh interval is CLK_MHZ·P/1000 cycles. P is 15625 for REF_MODE 0 (2,048 per 32 ms) and for REF_MODE 2 (4,096 per 64 ms), and 31250 for REF_MODE 1 (2,048 per 64 ms). A refresh becomes due every interval, counted from the mode register load. A due refresh is issued as AUTO REFRESH at the first point a command is allowed, and it is followed by a T_RC gap.
- R11: When a refresh is due and a request is valid at the same point, the refresh is issued first and reqReady stays low until the refresh gap has passed.
- R12: Commands are coded on {RAS#,CAS#,WE#} as NOP 111, ACTIVE 011, READ 101, WRITE 100, PRECHARGE 010, AUTO REFRESH 001 and LOAD MODE REGISTER 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | High for write, low for read |
| reqAddr | input | 20 | Word address: bank, row, column from high to low |
| reqReady | output | 1 | Request will be taken on the next edge if valid |
| csN | output | 1 | SDRAM chip select, active low |
| rasN | output | 1 | SDRAM row strobe, active low |
| casN | output | 1 | SDRAM column strobe, active low |
| weN | output | 1 | SDRAM write enable, active low |
| ba | output | 1 | SDRAM bank select |
| addr | output | 11 | SDRAM address A10..A0 |
| rdValid | output | 1 | Read data expected on the data bus this cycle |
| wrTake | output | 1 | Write data driven to the data bus this cycle |

## Verification
The conflict worth provoking is a refresh falling due at the same moment a host request is waiting. To force it, the bench keeps reqValid high without a break across two full refresh intervals, so some refresh must become due while a request is pending or arriving. A cycle-accurate model in the bench predicts, cycle by cycle, whether AUTO REFRESH or ACTIVE goes out and when reqReady returns. Every cycle is compared against that model, and the bench also counts the collisions it saw, so a run with no collision is itself judged a failure.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  // {RAS#, CAS#, WE#}
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } cmdCode_t;

  typedef struct packed {
    logic     fire;   // put a command on the bus next cycle
    cmdCode_t code;   // which command
    logic     grab;   // capture the host address
  } ctrlStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int refreshCycles(input int clkMhz, input int mode);
    int periodNs;
    case (mode)
      1:       periodNs = 31250;
      default: periodNs = 15625;
    endcase
    return clkMhz * periodNs / 1000;
  endfunction

  function automatic int burstCode(input int len);
    case (len)
      1:       return 0;
      2:       return 1;
      4:       return 2;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/sdseq_ctrl.sv
module sdseq_ctrl
  import sdseq_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int REF_MODE    = 1,
  parameter int POWERUP_CYC = 12500,
  parameter int T_RCD       = 2,
  parameter int T_RP        = 2,
  parameter int T_RC        = 7,
  parameter int T_MRD       = 2,
  parameter int T_WR        = 2,
  parameter int CAS_LAT     = 2,
  parameter int BURST_LEN   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);

  localparam int RD_GAP   = maxOf(CAS_LAT + BURST_LEN + T_RP, T_RC - T_RCD);
  localparam int WR_GAP   = maxOf(BURST_LEN + T_WR + T_RP, T_RC - T_RCD);
  localparam int REF_INT  = refreshCycles(CLK_MHZ, REF_MODE);
  localparam int MAX_WAIT = maxOf(maxOf(maxOf(POWERUP_CYC, T_RC), maxOf(T_RP, T_MRD)),
                                  maxOf(maxOf(RD_GAP, WR_GAP), T_RCD));
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int REF_W    = $clog2(REF_INT + 1);

  localparam logic [CNT_W-1:0] LD_PWR = CNT_W'(POWERUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 1);
  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_RDG = CNT_W'(RD_GAP - 1);
  localparam logic [CNT_W-1:0] LD_WRG = CNT_W'(WR_GAP - 1);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_INT - 1);

  typedef enum logic [2:0] {
    ST_PRE, ST_REFA, ST_REFB, ST_MODE, ST_IDLE, ST_COL
  } state_t;

  state_t           state, nextState;
  logic [CNT_W-1:0] waitCnt, loadVal;
  logic             load;
  logic             wrFlag;
  logic [REF_W-1:0] refTimer;
  logic             refLive, refPend, refTick;
  logic             setLive, clrPend;

  always_comb begin
    nextState = state;
    load      = 1'b0;
    loadVal   = '0;
    setLive   = 1'b0;
    clrPend   = 1'b0;
    strobe    = '{fire: 1'b0, code: CMD_NOP, grab: 1'b0};
    if (waitCnt == '0) begin
      case (state)
        ST_PRE: begin
          strobe.fire = 1'b1; strobe.code = CMD_PRE;
          load = 1'b1; loadVal = LD_RP; nextState = ST_REFA;
        end
        ST_REFA: begin
          strobe.fire = 1'b1; strobe.code = CMD_REF;
          load = 1'b1; loadVal = LD_RC; nextState = ST_REFB;
        end
        ST_REFB: begin
          strobe.fire = 1'b1; strobe.code = CMD_REF;
          load = 1'b1; loadVal = LD_RC; nextState = ST_MODE;
        end
        ST_MODE: begin
          strobe.fire = 1'b1; strobe.code = CMD_MRS;
          load = 1'b1; loadVal = LD_MRD; nextState = ST_IDLE;
          setLive = 1'b1;
        end
        ST_IDLE: begin
          if (refPend) begin
            strobe.fire = 1'b1; strobe.code = CMD_REF;
            load = 1'b1; loadVal = LD_RC; clrPend = 1'b1;
          end else if (reqValid) begin
            strobe.fire = 1'b1; strobe.code = CMD_ACT; strobe.grab = 1'b1;
            load = 1'b1; loadVal = LD_RCD; nextState = ST_COL;
          end
        end
        ST_COL: begin
          strobe.fire = 1'b1;
          strobe.code = wrFlag ? CMD_WR : CMD_RD;
          load = 1'b1; loadVal = wrFlag ? LD_WRG : LD_RDG;
          nextState = ST_IDLE;
        end
        default: nextState = ST_PRE;
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE) && (waitCnt == '0) && !refPend;
  assign refTick  = refLive && (refTimer == REF_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PRE;
      waitCnt <= LD_PWR;
      wrFlag  <= 1'b0;
    end else begin
      state <= nextState;
      if (load)                waitCnt <= loadVal;
      else if (waitCnt != '0)  waitCnt <= waitCnt - 1'b1;
      if (strobe.grab)         wrFlag  <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refTimer <= '0;
      refLive  <= 1'b0;
      refPend  <= 1'b0;
    end else begin
      if (setLive) refLive <= 1'b1;
      if (refLive) refTimer <= refTick ? '0 : refTimer + 1'b1;
      if (refTick)      refPend <= 1'b1;
      else if (clrPend) refPend <= 1'b0;
    end
  end

endmodule

// File: rtl/sdseq_path.sv
module sdseq_path
  import sdseq_pkg::*;
#(
  parameter int BANK_W    = 1,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobe_t                     strobe,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   reqAddr,
  output logic                            csN,
  output logic                            rasN,
  output logic                            casN,
  output logic                            weN,
  output logic [BANK_W-1:0]               ba,
  output logic [ROW_W-1:0]                addr,
  output logic                            rdValid,
  output logic                            wrTake
);

  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int AP_BIT = ROW_W - 1;
  localparam int RD_SPAN = CAS_LAT + BURST_LEN;
  localparam int RC_W   = $clog2(RD_SPAN + 1);
  localparam int WC_W   = $clog2(BURST_LEN + 1);
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'({3'(CAS_LAT), 1'b0, 3'(burstCode(BURST_LEN))});
  localparam logic [ROW_W-1:0] AP_MASK = ROW_W'(1) << AP_BIT;

  logic [BANK_W-1:0] bankQ;
  logic [COL_W-1:0]  colQ;
  logic [BANK_W-1:0] nextBa;
  logic [ROW_W-1:0]  nextAddr;
  logic [ROW_W-1:0]  colWord;
  cmdCode_t          cmdQ;
  logic [RC_W-1:0]   rdCnt;
  logic [WC_W-1:0]   wrCnt;

  // column word: start column in the low bits, auto-precharge bit set
  generate
    if (COL_W < ROW_W) begin : g_colPad
      assign colWord = AP_MASK | ROW_W'(colQ);
    end else begin : g_colFull
      assign colWord = AP_MASK | colQ[ROW_W-1:0];
    end
  endgenerate

  always_comb begin
    nextBa   = '0;
    nextAddr = '0;
    case (strobe.code)
      CMD_PRE: nextAddr = AP_MASK;
      CMD_MRS: nextAddr = MODE_WORD;
      CMD_ACT: begin
        nextBa   = reqAddr[ADDR_W-1 -: BANK_W];
        nextAddr = reqAddr[COL_W +: ROW_W];
      end
      CMD_RD, CMD_WR: begin
        nextBa   = bankQ;
        nextAddr = colWord;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ <= '0;
      colQ  <= '0;
    end else if (strobe.grab) begin
      bankQ <= reqAddr[ADDR_W-1 -: BANK_W];
      colQ  <= reqAddr[COL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN  <= 1'b1;
      cmdQ <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
    end else begin
      csN  <= 1'b0;
      cmdQ <= strobe.fire ? strobe.code : CMD_NOP;
      ba   <= strobe.fire ? nextBa : '0;
      addr <= strobe.fire ? nextAddr : '0;
    end
  end

  assign {rasN, casN, weN} = cmdQ;

  // data windows derived from the command actually on the bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdCnt <= '0;
      wrCnt <= '0;
    end else begin
      if (cmdQ == CMD_RD)     rdCnt <= RC_W'(RD_SPAN - 1);
      else if (rdCnt != '0)   rdCnt <= rdCnt - 1'b1;
      if (cmdQ == CMD_WR)     wrCnt <= WC_W'(BURST_LEN - 1);
      else if (wrCnt != '0)   wrCnt <= wrCnt - 1'b1;
    end
  end

  assign rdValid = (rdCnt != '0) && (rdCnt <= RC_W'(BURST_LEN));
  assign wrTake  = (cmdQ == CMD_WR) || (wrCnt != '0);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdseq_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int REF_MODE    = 1,
  parameter int POWERUP_CYC = 12500,
  parameter int T_RCD       = 2,
  parameter int T_RP        = 2,
  parameter int T_RC        = 7,
  parameter int T_MRD       = 2,
  parameter int T_WR        = 2,
  parameter int CAS_LAT     = 2,
  parameter int BURST_LEN   = 4,
  parameter int BANK_W      = 1,
  parameter int ROW_W       = 11,
  parameter int COL_W       = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic [BANK_W+ROW_W+COL_W-1:0] reqAddr,
  output logic                          reqReady,
  output logic                          csN,
  output logic                          rasN,
  output logic                          casN,
  output logic                          weN,
  output logic [BANK_W-1:0]             ba,
  output logic [ROW_W-1:0]              addr,
  output logic                          rdValid,
  output logic                          wrTake
);

  ctrlStrobe_t strobe;

  sdseq_ctrl #(
    .CLK_MHZ(CLK_MHZ), .REF_MODE(REF_MODE), .POWERUP_CYC(POWERUP_CYC),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .T_WR(T_WR),
    .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strobe(strobe)
  );

  sdseq_path #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .rdValid(rdValid), .wrTake(wrTake)
  );

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
  parameter int T_RCD     = 2,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4,
  parameter int BANK_W    = 1,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          reqValid,
  input logic                          reqWrite,
  input logic [BANK_W+ROW_W+COL_W-1:0] reqAddr,
  input logic                          reqReady,
  input logic                          csN,
  input logic                          rasN,
  input logic                          casN,
  input logic                          weN,
  input logic [BANK_W-1:0]             ba,
  input logic [ROW_W-1:0]              addr,
  input logic                          rdValid,
  input logic                          wrTake
);

  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int AP_BIT = ROW_W - 1;

  logic [2:0] busCmd;
  logic       isAct, isCol, isPre, isMrs, accepted;
  logic [7:0] sinceAct;
  logic [2:0] blField;
  logic [ROW_W-1:0] modeExp;

  assign busCmd   = {rasN, casN, weN};
  assign isAct    = !csN && busCmd == 3'b011;
  assign isCol    = !csN && (busCmd == 3'b101 || busCmd == 3'b100);
  assign isPre    = !csN && busCmd == 3'b010;
  assign isMrs    = !csN && busCmd == 3'b000;
  assign accepted = reqValid && reqReady;

  always_comb begin
    case (BURST_LEN)
      1:       blField = 3'd0;
      2:       blField = 3'd1;
      4:       blField = 3'd2;
      default: blField = 3'd3;
    endcase
    modeExp = '0;
    modeExp[2:0] = blField;
    modeExp[6:4] = 3'(CAS_LAT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceAct <= '0;
    else if (isAct)            sinceAct <= 8'd1;
    else if (sinceAct != 8'hFF) sinceAct <= sinceAct + 8'd1;
  end

  p_act_after_accept_r5: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> (isAct && ba == $past(reqAddr[ADDR_W-1 -: BANK_W])
                  && addr == $past(reqAddr[COL_W +: ROW_W])));

  p_col_spacing_r6: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> sinceAct == 8'(T_RCD));

  p_col_autopre_r6: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> addr[AP_BIT]);

  p_pre_all_r2: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> addr[AP_BIT]);

  p_mode_word_r3: assert property (@(posedge clk) disable iff (!rstN)
    isMrs |-> (addr == modeExp && ba == '0));

  p_windows_apart_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdValid, wrTake}));

  p_ready_drops_r4: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> !reqReady);

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .T_RCD(T_RCD), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN),
  .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqReady(reqReady), .csN(csN), .rasN(rasN),
  .casN(casN), .weN(weN), .ba(ba), .addr(addr), .rdValid(rdValid),
  .wrTake(wrTake)
);

// File: tb/sdram_cmd_seq_test.sv
module sdram_cmd_seq_test;

  localparam int PWR = 20, TRCD = 2, TRP = 2, TRC = 7, TMRD = 2, TWR = 2;
  localparam int CL = 2, BL = 4;
  localparam int REFINT = 125 * 15625 / 1000;   // R10: mode 0 at 125 MHz
  localparam int RDGAP = (CL + BL + TRP > TRC - TRCD) ? CL + BL + TRP : TRC - TRCD;
  localparam int WRGAP = (BL + TWR + TRP > TRC - TRCD) ? BL + TWR + TRP : TRC - TRCD;
  localparam logic [10:0] MODEW = {4'b0, 3'(CL), 1'b0, 3'd2};

  logic clk = 0, rstN = 0, reqValid = 0, reqWrite = 0;
  logic [19:0] reqAddr = '0;
  logic reqReady, csN, rasN, casN, weN, ba, rdValid, wrTake;
  logic [10:0] addr;

  int total = 0, bad = 0, wd = 0;

  always #4 clk = ~clk;

  sdram_cmd_seq #(
    .CLK_MHZ(125), .REF_MODE(0), .POWERUP_CYC(PWR), .T_RCD(TRCD), .T_RP(TRP),
    .T_RC(TRC), .T_MRD(TMRD), .T_WR(TWR), .CAS_LAT(CL), .BURST_LEN(BL)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqReady(reqReady), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .ba(ba), .addr(addr), .rdValid(rdValid),
    .wrTake(wrTake)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // ---------------- reference model ----------------
  int cyc = 0, phase = 0, nextAt = 0, refDue = 0, colAt = 0;
  int lastRd = -1000, lastWr = -1000, lastColAt = -1000, lastGap = 0;
  int refSeen = 0, collide = 0;
  bit pend = 0, colWr = 0, colBank = 0;
  logic [7:0] colCol = '0;
  bit eCs, eBa, eReady, eRd, eWr;
  bit [2:0] eCmd;
  bit [10:0] eAddr;
  string tagCmd = "R12", tagReady = "R4";

  always @(posedge clk) begin
    if (!rstN) begin
      cyc = 0; phase = 0; pend = 0;
    end else begin
      cyc++;
      eCs = 0; eCmd = 3'b111; eBa = 0; eAddr = '0; tagCmd = "R12";
      if (phase == 0) begin
        if (cyc == PWR) begin
          eCmd = 3'b010; eAddr = 11'h400; tagCmd = "R2";
        end else if (cyc == PWR + TRP || cyc == PWR + TRP + TRC) begin
          eCmd = 3'b001; tagCmd = "R2";
        end else if (cyc == PWR + TRP + 2 * TRC) begin
          eCmd = 3'b000; eAddr = MODEW; tagCmd = "R3";
          phase = 1; nextAt = cyc + TMRD; refDue = cyc + REFINT;
        end
      end else if (phase == 1) begin
        if (cyc >= nextAt) begin
          if (pend) begin
            eCmd = 3'b001; tagCmd = "R10"; pend = 0; nextAt = cyc + TRC;
            refSeen++;
            if (reqValid) collide++;
          end else if (reqValid) begin
            eCmd = 3'b011; eBa = reqAddr[19]; eAddr = reqAddr[18:8]; tagCmd = "R5";
            colAt = cyc + TRCD; colWr = reqWrite; colBank = reqAddr[19];
            colCol = reqAddr[7:0]; phase = 2;
          end
        end
      end else if (cyc == colAt) begin
        eCmd = colWr ? 3'b100 : 3'b101; eBa = colBank;
        eAddr = 11'h400 | {3'b0, colCol}; tagCmd = "R6";
        lastGap = colWr ? WRGAP : RDGAP;
        nextAt = cyc + lastGap; lastColAt = cyc;
        if (colWr) lastWr = cyc; else lastRd = cyc;
        phase = 1;
      end
      if (phase != 0 && cyc == refDue) begin
        pend = 1; refDue += REFINT;
      end
      eReady = (phase == 1) && (cyc + 1 >= nextAt) && !pend;
      tagReady = pend ? "R11" : ((cyc < lastColAt + lastGap) ? "R7" : "R4");
      eRd = (cyc >= lastRd + CL) && (cyc <= lastRd + CL + BL - 1);
      eWr = (cyc >= lastWr) && (cyc <= lastWr + BL - 1);
    end
  end

  always @(negedge clk) begin
    if (rstN && cyc >= 1) begin
      chk(tagCmd, "csN", csN, eCs);
      chk(tagCmd, "cmd", {rasN, casN, weN}, eCmd);
      chk(tagCmd, "ba", ba, eBa);
      chk(tagCmd, "addr", addr, eAddr);
      chk(tagReady, "reqReady", reqReady, eReady);
      chk("R8", "rdValid", rdValid, eRd);
      chk("R9", "wrTake", wrTake, eWr);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      total++; bad++;
      $display("FAIL R4 watchdog: actual=hung expected=finished");
      report();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic request(input bit w, input logic [19:0] a);
    reqValid = 1; reqWrite = w; reqAddr = a;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "csN", csN, 1);
    chk("R1", "cmd", {rasN, casN, weN}, 3'b111);
    chk("R1", "addr", addr, 0);
    chk("R1", "reqReady", reqReady, 0);
    chk("R1", "rdValid", rdValid, 0);
    chk("R1", "wrTake", wrTake, 0);
    rstN = 1;

    request(1'b1, 20'h12345);
    request(1'b0, 20'h8ABCD);
    request(1'b0, 20'hFFFFF);
    request(1'b1, 20'h00000);
    repeat (30) @(negedge clk);
    request(1'b0, 20'h80100);

    // continuous demand across two refresh intervals (R10, R11)
    for (int i = 0; cyc < PWR + TRP + 2 * TRC + 2 * REFINT + 40; i++)
      request(i[0], 20'(i * 32'h0B3C5));
    repeat (20) @(negedge clk);

    chk("R10", "refreshes seen", (refSeen >= 2) ? 1 : 0, 1);
    chk("R11", "refresh/request collisions", (collide >= 1) ? 1 : 0, 1);
    report();
    $finish;
  end

endmodule